// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit floating-point words. Each word holds a sign in the top bit, an 8-bit exponent carrying a bias of 127, and a 23-bit fraction with an implied leading one. The datapath first unpacks both words and orders them by magnitude. It shifts the smaller significand right to line it up and works out whether the magnitudes are summed or differenced. It then normalises with a leading-zero count, rounds to nearest-even, renormalises if the rounding carries out, and packs the result.

The arithmetic is a single combinational path. Its result and two range flags are captured in an output register, so a result appears one clock after its operands. Exponent overflow saturates to the largest finite magnitude. Exponent underflow flushes to zero. An operand whose exponent field is zero is taken as zero, and no other special values are decoded.

Top module: `fp_addsub`

## Requirements
- R1: Words are laid out as sign in bit 31, biased exponent (bias 127) in bits 30..23 and fraction in bits 22..0, with a hidden leading one; for example 1.0 + 2.0 gives 0x40400000.
- R2: Before the magnitudes are combined, the significand of the operand with the smaller exponent is shifted right by the exponent difference. Bits shifted past the guard and round positions still affect rounding through a sticky bit.
- R3: With `op_sub` = 0 the block computes a + b, and with `op_sub` = 1 it computes a − b. Magnitudes are summed when the effective signs agree and differenced otherwise.
- R4: A carry out of the magnitude sum shifts the significand right by one and raises the exponent by one.
- R5: After a difference, leading zeros are removed by a left shift, and the exponent drops by the shift amount.
- R6: Rounding is to nearest, with ties going to an even last fraction bit.
- R7: When rounding carries out of the significand, the result shifts right once more and the exponent rises by one.
- R8: The result takes the sign of the larger-magnitude operand. An exact cancellation, and any zero result, is +0 (0x00000000).
- R9: If the final biased exponent would reach 255, `ovf` is 1 and the result is the largest finite value with the result sign, with the exponent field at 254 and all fraction bits set.
- R10: If the final biased exponent would be 0 or below, `unf` is 1 and the result is 0x00000000.
- R11: An operand whose exponent field is 0 is treated as zero, whatever its fraction bits hold.
- R12: `res`, `ovf` and `unf` are registered. They hold zero while `rst_n` is low and show the result for the operands present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| op_sub | input | 1 | 0 selects add, 1 selects subtract |
| res | output | 32 | Registered result |
| ovf | output | 1 | Registered exponent overflow flag |
| unf | output | 1 | Registered exponent underflow flag |

## Verification
The bench builds the block with its default 8-bit exponent and 23-bit fraction, because its reference model widens the operands to double-precision reals. With those widths it keeps the exponent gap of random operands at 24 or less, so the double-precision sum is exact and a single round to 24 bits gives the correct expected word. That range exercises every alignment shift up to the full significand width. It also reaches the cancellation left shift, the carry-out and rounding-overflow paths, and both exponent limits. Directed cases add gaps beyond the significand width, ties that round each way, and operands with a zero exponent field.

// File: rtl/fp_addsub.sv
module fp_addsub #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] opa,
  input  logic [WORD_W-1:0] opb,
  input  logic              op_sub,
  output logic [WORD_W-1:0] res,
  output logic              ovf,
  output logic              unf
);
  localparam int MW   = FRAC_W + 1;
  localparam int XW   = MW + 3;
  localparam int ZW   = $clog2(XW) + 1;
  localparam int SEW  = EXP_W + 3;
  localparam int EMAX = (1 << EXP_W) - 1;

  function automatic logic [ZW-1:0] lead0(input logic [XW-1:0] v);
    lead0 = ZW'(XW);
    for (int i = 0; i < XW; i++)
      if (v[i]) lead0 = ZW'(XW - 1 - i);
  endfunction

  logic [EXP_W-1:0] ea, eb;
  assign ea = opa[WORD_W-2:FRAC_W];
  assign eb = opb[WORD_W-2:FRAC_W];

  logic [WORD_W-2:0] ka, kb;
  assign ka = (ea == '0) ? '0 : opa[WORD_W-2:0];
  assign kb = (eb == '0) ? '0 : opb[WORD_W-2:0];

  logic sa, sb, a_big, s_l, eff_sub;
  assign sa      = opa[WORD_W-1];
  assign sb      = opb[WORD_W-1] ^ op_sub;
  assign a_big   = ka >= kb;
  assign s_l     = a_big ? sa : sb;
  assign eff_sub = sa ^ sb;

  logic [EXP_W-1:0]  e_l, e_s, diff;
  logic [WORD_W-2:0] k_l, k_s;
  assign k_l  = a_big ? ka : kb;
  assign k_s  = a_big ? kb : ka;
  assign e_l  = k_l[WORD_W-2:FRAC_W];
  assign e_s  = k_s[WORD_W-2:FRAC_W];
  assign diff = e_l - e_s;

  logic [XW-1:0] x_l, x_s, x_sh, x_al;
  logic          lost;
  assign x_l  = (e_l == '0) ? '0 : {1'b1, k_l[FRAC_W-1:0], 3'b000};
  assign x_s  = (e_s == '0) ? '0 : {1'b1, k_s[FRAC_W-1:0], 3'b000};
  assign x_sh = (32'(diff) >= XW) ? '0 : (x_s >> diff);
  assign lost = (32'(diff) >= XW) ? |x_s : |(x_s & ~({XW{1'b1}} << diff));
  assign x_al = {x_sh[XW-1:1], x_sh[0] | lost};

  logic [XW:0] raw;
  assign raw = eff_sub ? ({1'b0, x_l} - {1'b0, x_al}) : ({1'b0, x_l} + {1'b0, x_al});

  logic [ZW-1:0]         z;
  logic [XW-1:0]         norm;
  logic signed [SEW-1:0] e_n, e_f;
  logic [MW:0]           rnd;
  logic [MW-1:0]         mant;
  logic                  inc;
  logic [WORD_W-1:0]     res_d;
  logic                  ovf_d, unf_d;

  assign z = lead0(raw[XW-1:0]);

  always_comb begin
    if (raw[XW]) begin
      norm = {raw[XW:2], |raw[1:0]};
      e_n  = $signed(SEW'(e_l)) + 1;
    end else begin
      norm = raw[XW-1:0] << z;
      e_n  = $signed(SEW'(e_l)) - $signed(SEW'(z));
    end
    inc = norm[2] & (norm[1] | norm[0] | norm[3]);
    rnd = {1'b0, norm[XW-1:3]} + (MW+1)'(inc);
    if (rnd[MW]) begin
      mant = rnd[MW:1];
      e_f  = e_n + 1;
    end else begin
      mant = rnd[MW-1:0];
      e_f  = e_n;
    end
    ovf_d = 1'b0;
    unf_d = 1'b0;
    if (raw == '0) begin
      res_d = '0;
    end else if (e_f >= $signed(SEW'(EMAX))) begin
      ovf_d = 1'b1;
      res_d = {s_l, EXP_W'(EMAX - 1), {FRAC_W{1'b1}}};
    end else if (e_f <= 0) begin
      unf_d = 1'b1;
      res_d = '0;
    end else begin
      res_d = {s_l, e_f[EXP_W-1:0], mant[FRAC_W-1:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      res <= res_d;
      ovf <= ovf_d;
      unf <= unf_d;
    end
  end
endmodule

// File: rtl/fp_addsub_chk.sv
module fp_addsub_chk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] opa,
  input logic [WORD_W-1:0] opb,
  input logic              op_sub,
  input logic [WORD_W-1:0] res,
  input logic              ovf,
  input logic              unf
);
  // R9
  saturate_on_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> res[WORD_W-2:0] == {EXP_W'((1 << EXP_W) - 2), {FRAC_W{1'b1}}});

  // R10
  flush_on_unf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unf |-> res == '0);

  // R9
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf && unf));

  // R8
  self_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(op_sub) && $past(opa) == $past(opb)) |-> (res == '0 && !ovf && !unf));

  // R11
  zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(opb[WORD_W-2:FRAC_W]) == '0 && $past(opa[WORD_W-2:FRAC_W]) != '0)
      |-> res == $past(opa));

  // R12
  reset_clear_chk: assert property (@(posedge clk)
    $past(!rst_n) |-> (res == '0 && !ovf && !unf));
endmodule

bind fp_addsub fp_addsub_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .op_sub(op_sub),
  .res(res), .ovf(ovf), .unf(unf)
);

// File: tb/fp_addsub_tb.sv
module fp_addsub_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic        op_sub = 1'b0;
  logic [31:0] res;
  logic        ovf, unf;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  fp_addsub dut_i (.clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .op_sub(op_sub),
                   .res(res), .ovf(ovf), .unf(unf));

  function automatic real to_real(input logic [31:0] x);
    logic [63:0] bits;
    if (x[30:23] == 8'd0) return 0.0;
    bits = {x[31], 11'(x[30:23]) - 11'd127 + 11'd1023, x[22:0], 29'd0};
    return $bitstoreal(bits);
  endfunction

  function automatic void model(input logic [31:0] x, input logic [31:0] y, input logic sub,
                                output logic [31:0] r, output logic o, output logic u);
    real s;
    logic [63:0] bits;
    logic [24:0] k;
    int e;
    o = 1'b0; u = 1'b0; r = '0;
    s = sub ? to_real(x) - to_real(y) : to_real(x) + to_real(y);
    if (s == 0.0) return;
    bits = $realtobits(s);
    e = int'(bits[62:52]) - 1023;
    k = {2'b01, bits[51:29]};
    if (bits[28] && ((|bits[27:0]) || k[0])) k = k + 25'd1;
    if (k[24]) begin k = k >> 1; e = e + 1; end
    if (e > 127) begin o = 1'b1; r = {bits[63], 8'hFE, 23'h7FFFFF}; end
    else if (e < -126) u = 1'b1;
    else r = {bits[63], 8'(e + 127), k[22:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp,
                       input logic go, input logic eo, input logic gu, input logic eu);
    n_chk++;
    if (got !== exp || go !== eo || gu !== eu) begin
      n_err++;
      $display("FAIL %s: got res=%h ovf=%b unf=%b expected res=%h ovf=%b unf=%b",
               tag, got, go, gu, exp, eo, eu);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] x, input logic [31:0] y, input logic sub);
    logic [31:0] r; logic o, u;
    model(x, y, sub, r, o, u);
    @(negedge clk);
    opa = x; opb = y; op_sub = sub;
    @(posedge clk); #1;
    check(tag, res, r, ovf, o, unf, u);
  endtask

  task automatic run_exp(input string tag, input logic [31:0] x, input logic [31:0] y,
                         input logic sub, input logic [31:0] r, input logic o, input logic u);
    @(negedge clk);
    opa = x; opb = y; op_sub = sub;
    @(posedge clk); #1;
    check(tag, res, r, ovf, o, unf, u);
  endtask

  initial begin
    void'($urandom(32'd7021));
    opa = 32'h40400000; opb = 32'h3F800000;
    repeat (3) @(posedge clk);
    #1 check("R12 reset clears outputs", res, 32'h0, ovf, 1'b0, unf, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    run_exp("R1 1.0+2.0", 32'h3F800000, 32'h40000000, 1'b0, 32'h40400000, 1'b0, 1'b0);
    @(negedge clk); opa = 32'h40800000; opb = 32'h40800000; op_sub = 1'b0;
    #1 check("R12 output holds until edge", res, 32'h40400000, ovf, 1'b0, unf, 1'b0);
    @(posedge clk); #1;
    check("R12 result after one edge", res, 32'h41000000, ovf, 1'b0, unf, 1'b0);

    run_exp("R2 256.25+375.75", 32'h43802000, 32'h43BBE000, 1'b0, 32'h441E0000, 1'b0, 1'b0);
    run_exp("R8 256.25-375.75", 32'h43802000, 32'h43BBE000, 1'b1, 32'hC2EF0000, 1'b0, 1'b0);
    run_exp("R5 14.0-10.0", 32'h41600000, 32'h41200000, 1'b1, 32'h40800000, 1'b0, 1'b0);
    run_exp("R3 3.0-(-1.0)", 32'h40400000, 32'hBF800000, 1'b1, 32'h40800000, 1'b0, 1'b0);
    run_exp("R3 -1.0+-2.0", 32'hBF800000, 32'hC0000000, 1'b0, 32'hC0400000, 1'b0, 1'b0);
    run_exp("R4 1.5+1.5", 32'h3FC00000, 32'h3FC00000, 1'b0, 32'h40400000, 1'b0, 1'b0);
    run_exp("R8 1.0-3.0", 32'h3F800000, 32'h40400000, 1'b1, 32'hC0000000, 1'b0, 1'b0);
    run_exp("R8 exact cancel", 32'hC0400000, 32'hC0400000, 1'b1, 32'h00000000, 1'b0, 1'b0);
    run_exp("R6 tie to even down", 32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 1'b0, 1'b0);
    run_exp("R6 tie to even up", 32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 1'b0, 1'b0);
    run_exp("R7 rounding carry", 32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 1'b0, 1'b0);
    run_exp("R2 sticky beyond width", 32'h3F800000, 32'h30800000, 1'b0, 32'h3F800000, 1'b0, 1'b0);
    run_exp("R2 sticky on subtract", 32'h3F800000, 32'h30800000, 1'b1, 32'h3F800000, 1'b0, 1'b0);
    run_exp("R9 positive overflow", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F7FFFFF, 1'b1, 1'b0);
    run_exp("R9 negative overflow", 32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 32'hFF7FFFFF, 1'b1, 1'b0);
    run_exp("R10 underflow", 32'h00800001, 32'h00800000, 1'b1, 32'h00000000, 1'b0, 1'b1);
    run_exp("R11 zero plus 3.0", 32'h00000000, 32'h40400000, 1'b0, 32'h40400000, 1'b0, 1'b0);
    run_exp("R11 zero minus 3.0", 32'h00000000, 32'h40400000, 1'b1, 32'hC0400000, 1'b0, 1'b0);
    run_exp("R11 zero-exp fraction ignored", 32'h00000123, 32'h3F800000, 1'b0, 32'h3F800000, 1'b0, 1'b0);
    run_exp("R11 both zero", 32'h80000000, 32'h00000456, 1'b0, 32'h00000000, 1'b0, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      int ea, eb, mode;
      logic [31:0] x, y;
      mode = int'($urandom % 8);
      if (mode == 0) ea = 1 + int'($urandom % 4);
      else if (mode == 1) ea = 251 + int'($urandom % 4);
      else ea = 1 + int'($urandom % 254);
      eb = ea + int'($urandom % 49) - 24;
      if (eb < 1) eb = 1;
      if (eb > 254) eb = 254;
      x = {1'($urandom), 8'(ea), 23'($urandom)};
      y = {1'($urandom), 8'(eb), 23'($urandom)};
      if (mode == 2) y = {y[31], x[30:4], 4'($urandom)};
      run("R2 R3 R5 R6 random vs model", x, y, 1'($urandom));
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule